// File: doc/BRIEF.md
# Display Output Pixel Formatter

This block is the last stage in front of a parallel pixel bus. Each clock it can accept one pixel of three 12-bit components, marked by a valid flag. It turns that pixel into one output word made of three 16-bit slots. For luma/chroma formats it limits the components to a programmable legal range. It can reverse the red and blue inputs and reorder the three channels. It can pack luma and chroma into one-lane or two-lane sequences, and it scales each component to the width the panel link needs. Colour-space conversion and sync timing are handled elsewhere. The only timing the block carries is its valid flag, delayed to match the data.

All configuration is static. The configuration inputs are captured on every clock edge while `rst_n` is low and then held until the next reset. The input components are called ch0, ch1 and ch2. In RGB terms they are red, green and blue. In luma/chroma terms ch1 is luma and ch0/ch2 are the two chroma samples.

Top module: `pix_out_fmt`

## Requirements
- R1: With format code 0 (RGB) or 3, the slots {slot0, slot1, slot2} are set by the order code as follows: 0 → {ch0,ch1,ch2}, 1 → {ch1,ch2,ch0}, 2 → {ch2,ch0,ch1}, 3 → {ch0,ch2,ch1}, 4 → {ch1,ch0,ch2}, 5 → {ch2,ch1,ch0}. Codes 6 and 7 act as code 0. slot0 occupies out_word[47:32], slot1 occupies [31:16] and slot2 occupies [15:0]. In RGB format no component is clamped.
- R2: With format code 1 or 2, luma (ch1) becomes min(max(ch1, luma_low), luma_high).
- R3: With format code 1 or 2, ch0 and ch2 are each clamped in the same way against the chroma low and high limits.
- R4: When the default-limit input is sampled high, the limits are 0x010 (low) and 0xFE0 (high) for both luma and chroma, and the four limit inputs are ignored.
- R5: Format code 1 (4:4:4 luma/chroma) forces order code 5 whatever the order input is, and does not swap the inputs.
- R6: Format code 2 (4:2:2) first exchanges ch0 and ch2 and then forces order code 0, so the slots are {ch2, ch1, ch0}.
- R7: Packing code 3 (CY) gives slot0 = C and slot1 = Y. Packing code 4 (YC) gives slot0 = Y and slot1 = C. In both, slot2 is zero. Y is the permuted slot1. C is the permuted slot0 on even pixels and the permuted slot2 on odd pixels. Packing codes 0, 5, 6 and 7 leave the three slots unpacked.
- R8: Packing code 1 (CYCY) puts C on even pixels and Y on odd pixels into slot0. Packing code 2 (YCYC) puts Y on even pixels and C on odd pixels into slot0. In both, slot1 and slot2 are zero.
- R9: The pixel phase toggles on every valid pixel. A valid pixel with line-start high is even. The phase is held while valid is low, and line-start has no effect when valid is low.
- R10: The width code selects how each 12-bit value v fills its 16-bit slot: 0 → v[11:4], 1 → v[11:2], 2 → v, 3 → {v, 4'b0}. Codes 4 to 7 act as code 0. The unused high bits of the slot are zero.
- R11: out_valid equals in_valid delayed by exactly two clocks, and out_word carries the matching pixel. During and after reset, out_valid and out_word are zero until the first pixel arrives.
- R12: Configuration inputs that change while `rst_n` is high have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cfg_fmt | input | 2 | Format: 0 RGB, 1 luma/chroma 4:4:4, 2 luma/chroma 4:2:2, 3 as RGB |
| cfg_order | input | 3 | Channel order code |
| cfg_pack | input | 3 | Luma/chroma packing code |
| cfg_width | input | 3 | Output component width code |
| cfg_lim_def | input | 1 | Use the default clamp limits |
| cfg_y_lo | input | 12 | Luma low limit |
| cfg_y_hi | input | 12 | Luma high limit |
| cfg_c_lo | input | 12 | Chroma low limit |
| cfg_c_hi | input | 12 | Chroma high limit |
| in_valid | input | 1 | Input pixel valid |
| in_line_start | input | 1 | First pixel of a line |
| in_ch0 | input | 12 | Component 0 (red / chroma) |
| in_ch1 | input | 12 | Component 1 (green / luma) |
| in_ch2 | input | 12 | Component 2 (blue / chroma) |
| out_valid | output | 1 | Output word valid |
| out_word | output | 48 | Three 16-bit output slots |

## Verification
The assertions rely on the configuration inputs being driven to known values for at least one clock edge while `rst_n` is low. The range checks assume low ≤ high. They also assume that in_valid and in_line_start are never unknown once reset is released. The bench applies every configuration through a reset sequence of three clocks with the pixel inputs idle. It sets every limit pair so that low ≤ high, and it changes pixel inputs only on the falling clock edge. Line-start is raised only together with valid, except in one deliberate check that it is ignored while valid is low.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int COMP_W = 12;
  localparam int SLOT_W = 16;
  localparam int NSLOT  = 3;

  localparam logic [1:0] FMT_RGB    = 2'd0;
  localparam logic [1:0] FMT_YCC444 = 2'd1;
  localparam logic [1:0] FMT_YCC422 = 2'd2;

  localparam logic [2:0] ORD_STRAIGHT = 3'd0;
  localparam logic [2:0] ORD_REVERSED = 3'd5;

  localparam logic [2:0] PK_NONE  = 3'd0;
  localparam logic [2:0] PK_CYCY  = 3'd1;
  localparam logic [2:0] PK_YCYC  = 3'd2;
  localparam logic [2:0] PK_CY    = 3'd3;
  localparam logic [2:0] PK_YC    = 3'd4;
endpackage

// File: rtl/pof_front.sv
module pof_front #(
  parameter int CW = pof_pkg::COMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt,
  input  logic [2:0]    order,
  input  logic [CW-1:0] y_lo,
  input  logic [CW-1:0] y_hi,
  input  logic [CW-1:0] c_lo,
  input  logic [CW-1:0] c_hi,
  input  logic          in_valid,
  input  logic          in_line_start,
  input  logic [CW-1:0] in_ch0,
  input  logic [CW-1:0] in_ch1,
  input  logic [CW-1:0] in_ch2,
  output logic          v_q,
  output logic [CW-1:0] s0_q,
  output logic [CW-1:0] s1_q,
  output logic [CW-1:0] s2_q,
  output logic          odd_q,
  output logic          clamp_on,
  output logic [CW-1:0] luma_cl,
  output logic [CW-1:0] ch0_cl,
  output logic [CW-1:0] ch2_cl,
  output logic          phase_q
);
  import pof_pkg::*;

  function automatic logic [CW-1:0] clamp_range(input logic [CW-1:0] v,
                                               input logic [CW-1:0] lo,
                                               input logic [CW-1:0] hi);
    logic [CW-1:0] t;
    t = (v < lo) ? lo : v;
    return (t > hi) ? hi : t;
  endfunction

  function automatic logic [3*CW-1:0] permute(input logic [2:0] code,
                                              input logic [CW-1:0] a,
                                              input logic [CW-1:0] b,
                                              input logic [CW-1:0] c);
    case (code)
      3'd1:    return {b, c, a};
      3'd2:    return {c, a, b};
      3'd3:    return {a, c, b};
      3'd4:    return {b, a, c};
      3'd5:    return {c, b, a};
      default: return {a, b, c};
    endcase
  endfunction

  logic          swap_rb;
  logic [2:0]    eff_order;
  logic [CW-1:0] pre_a, pre_c;
  logic [3*CW-1:0] slots;
  logic          pix_odd;

  always_comb begin
    clamp_on  = (fmt == FMT_YCC444) || (fmt == FMT_YCC422);
    luma_cl   = clamp_on ? clamp_range(in_ch1, y_lo, y_hi) : in_ch1;
    ch0_cl    = clamp_on ? clamp_range(in_ch0, c_lo, c_hi) : in_ch0;
    ch2_cl    = clamp_on ? clamp_range(in_ch2, c_lo, c_hi) : in_ch2;
    swap_rb   = (fmt == FMT_YCC422);
    pre_a     = swap_rb ? ch2_cl : ch0_cl;
    pre_c     = swap_rb ? ch0_cl : ch2_cl;
    if (fmt == FMT_YCC422)      eff_order = ORD_STRAIGHT;
    else if (fmt == FMT_YCC444) eff_order = ORD_REVERSED;
    else                        eff_order = order;
    slots     = permute(eff_order, pre_a, luma_cl, pre_c);
    pix_odd   = in_line_start ? 1'b0 : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      s0_q    <= '0;
      s1_q    <= '0;
      s2_q    <= '0;
      odd_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        s0_q    <= slots[3*CW-1 -: CW];
        s1_q    <= slots[2*CW-1 -: CW];
        s2_q    <= slots[CW-1:0];
        odd_q   <= pix_odd;
        phase_q <= ~pix_odd;
      end
    end
  end
endmodule

// File: rtl/pof_pack.sv
module pof_pack #(
  parameter int CW = pof_pkg::COMP_W,
  parameter int SW = pof_pkg::SLOT_W,
  parameter int NS = pof_pkg::NSLOT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_in,
  input  logic [CW-1:0]  s0,
  input  logic [CW-1:0]  s1,
  input  logic [CW-1:0]  s2,
  input  logic           odd,
  input  logic [2:0]     pack,
  input  logic [2:0]     width,
  output logic           out_valid,
  output logic [NS*SW-1:0] out_word
);
  import pof_pkg::*;

  function automatic logic [SW-1:0] fit(input logic [CW-1:0] v,
                                        input logic [2:0] code);
    int n;
    logic [SW-1:0] w;
    case (code)
      3'd1:    n = 10;
      3'd2:    n = 12;
      3'd3:    n = 16;
      default: n = 8;
    endcase
    w = SW'(v);
    if (n <= CW) w = w >> (CW - n);
    else         w = w << (n - CW);
    return w;
  endfunction

  logic [CW-1:0] lane [NS];
  logic [CW-1:0] luma, chroma;
  logic [NS*SW-1:0] word_d;

  always_comb begin
    luma   = s1;
    chroma = odd ? s2 : s0;
    lane[0] = s0;
    lane[1] = s1;
    lane[2] = s2;
    case (pack)
      PK_CYCY: begin lane[0] = odd ? luma : chroma; lane[1] = '0; lane[2] = '0; end
      PK_YCYC: begin lane[0] = odd ? chroma : luma; lane[1] = '0; lane[2] = '0; end
      PK_CY:   begin lane[0] = chroma; lane[1] = luma;   lane[2] = '0; end
      PK_YC:   begin lane[0] = luma;   lane[1] = chroma; lane[2] = '0; end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NS; i++) begin : g_slot
    assign word_d[(NS-1-i)*SW +: SW] = fit(lane[i], width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= v_in;
      if (v_in) out_word <= word_d;
    end
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt #(
  parameter int CW = pof_pkg::COMP_W,
  parameter int SW = pof_pkg::SLOT_W,
  parameter int NS = pof_pkg::NSLOT,
  parameter logic [CW-1:0] LO_DEF = CW'(12'h010),
  parameter logic [CW-1:0] HI_DEF = CW'(12'hFE0)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_fmt,
  input  logic [2:0]       cfg_order,
  input  logic [2:0]       cfg_pack,
  input  logic [2:0]       cfg_width,
  input  logic             cfg_lim_def,
  input  logic [CW-1:0]    cfg_y_lo,
  input  logic [CW-1:0]    cfg_y_hi,
  input  logic [CW-1:0]    cfg_c_lo,
  input  logic [CW-1:0]    cfg_c_hi,
  input  logic             in_valid,
  input  logic             in_line_start,
  input  logic [CW-1:0]    in_ch0,
  input  logic [CW-1:0]    in_ch1,
  input  logic [CW-1:0]    in_ch2,
  output logic             out_valid,
  output logic [NS*SW-1:0] out_word
);
  logic [1:0]    fmt_q;
  logic [2:0]    order_q, pack_q, width_q;
  logic [CW-1:0] y_lo_q, y_hi_q, c_lo_q, c_hi_q;

  // Static configuration: loaded only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q   <= cfg_fmt;
      order_q <= cfg_order;
      pack_q  <= cfg_pack;
      width_q <= cfg_width;
      y_lo_q  <= cfg_lim_def ? LO_DEF : cfg_y_lo;
      y_hi_q  <= cfg_lim_def ? HI_DEF : cfg_y_hi;
      c_lo_q  <= cfg_lim_def ? LO_DEF : cfg_c_lo;
      c_hi_q  <= cfg_lim_def ? HI_DEF : cfg_c_hi;
    end
  end

  logic          v1, odd1, clamp_on, phase_q;
  logic [CW-1:0] s0_1, s1_1, s2_1, luma_cl, ch0_cl, ch2_cl;

  pof_front #(.CW(CW)) front_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt_q), .order(order_q),
    .y_lo(y_lo_q), .y_hi(y_hi_q), .c_lo(c_lo_q), .c_hi(c_hi_q),
    .in_valid(in_valid), .in_line_start(in_line_start),
    .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
    .v_q(v1), .s0_q(s0_1), .s1_q(s1_1), .s2_q(s2_1), .odd_q(odd1),
    .clamp_on(clamp_on), .luma_cl(luma_cl), .ch0_cl(ch0_cl), .ch2_cl(ch2_cl),
    .phase_q(phase_q)
  );

  pof_pack #(.CW(CW), .SW(SW), .NS(NS)) pack_i (
    .clk(clk), .rst_n(rst_n), .v_in(v1), .s0(s0_1), .s1(s1_1), .s2(s2_1),
    .odd(odd1), .pack(pack_q), .width(width_q),
    .out_valid(out_valid), .out_word(out_word)
  );
endmodule

// File: rtl/pix_out_fmt_chk.sv
module pix_out_fmt_chk #(
  parameter int CW = 12,
  parameter int SW = 16,
  parameter int NS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_line_start,
  input logic             out_valid,
  input logic [NS*SW-1:0] out_word,
  input logic             clamp_on,
  input logic [CW-1:0]    luma_cl,
  input logic [CW-1:0]    ch0_cl,
  input logic [CW-1:0]    ch2_cl,
  input logic [CW-1:0]    y_lo_q,
  input logic [CW-1:0]    y_hi_q,
  input logic [CW-1:0]    c_lo_q,
  input logic [CW-1:0]    c_hi_q,
  input logic             phase_q,
  input logic [2:0]       pack_q,
  input logic [2:0]       width_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));  // R11
  AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clamp_on && (y_lo_q <= y_hi_q)) |->
      (luma_cl >= y_lo_q && luma_cl <= y_hi_q));  // R2
  AST_CHROMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clamp_on && (c_lo_q <= c_hi_q)) |->
      (ch0_cl >= c_lo_q && ch0_cl <= c_hi_q && ch2_cl >= c_lo_q && ch2_cl <= c_hi_q));  // R3
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_line_start) |=> phase_q);  // R9
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_line_start) |=> (phase_q != $past(phase_q)));  // R9
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));  // R9
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (width_q == 3'd0 || width_q > 3'd3)) |->
      (out_word[3*SW-1 -: SW-8] == '0 && out_word[2*SW-1 -: SW-8] == '0 &&
       out_word[SW-1 -: SW-8] == '0));  // R10
  AST_TWO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (pack_q == 3'd3 || pack_q == 3'd4)) |-> (out_word[SW-1:0] == '0));  // R7
endmodule

bind pix_out_fmt pix_out_fmt_chk #(.CW(CW), .SW(SW), .NS(NS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line_start(in_line_start),
  .out_valid(out_valid), .out_word(out_word), .clamp_on(clamp_on),
  .luma_cl(luma_cl), .ch0_cl(ch0_cl), .ch2_cl(ch2_cl),
  .y_lo_q(y_lo_q), .y_hi_q(y_hi_q), .c_lo_q(c_lo_q), .c_hi_q(c_hi_q),
  .phase_q(phase_q), .pack_q(pack_q), .width_q(width_q)
);

// File: tb/pix_out_fmt_tb_top.sv
module pix_out_fmt_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  b_fmt = 2'd0;
  logic [2:0]  b_order = 3'd0, b_pack = 3'd0, b_width = 3'd2;
  logic        b_lim_def = 1'b0;
  logic [11:0] b_ylo = 12'h000, b_yhi = 12'hFFF, b_clo = 12'h000, b_chi = 12'hFFF;
  logic        in_valid = 1'b0, in_line_start = 1'b0;
  logic [11:0] in_ch0 = '0, in_ch1 = '0, in_ch2 = '0;
  logic        out_valid;
  logic [47:0] out_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_out_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(b_fmt), .cfg_order(b_order),
    .cfg_pack(b_pack), .cfg_width(b_width), .cfg_lim_def(b_lim_def),
    .cfg_y_lo(b_ylo), .cfg_y_hi(b_yhi), .cfg_c_lo(b_clo), .cfg_c_hi(b_chi),
    .in_valid(in_valid), .in_line_start(in_line_start),
    .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
    .out_valid(out_valid), .out_word(out_word)
  );

  int checks = 0;
  int errors = 0;
  logic [1:0]  e_fmt;
  logic [2:0]  e_order, e_pack, e_width;
  logic [11:0] e_ylo, e_yhi, e_clo, e_chi;
  bit          tb_odd;
  logic [47:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] scale(input logic [11:0] v);
    case (e_width)
      3'd1:    return {6'd0, v[11:2]};
      3'd2:    return {4'd0, v};
      3'd3:    return {v, 4'd0};
      default: return {8'd0, v[11:4]};
    endcase
  endfunction

  function automatic logic [47:0] model(input logic [11:0] r, input logic [11:0] g,
                                        input logic [11:0] b, input bit odd);
    logic [11:0] x0, x1, x2, t, y, c;
    logic [11:0] sl [3];
    logic [2:0]  p;
    x0 = r; x1 = g; x2 = b;
    if (e_fmt == 2'd1 || e_fmt == 2'd2) begin
      if (x1 < e_ylo) x1 = e_ylo;
      if (x1 > e_yhi) x1 = e_yhi;
      if (x0 < e_clo) x0 = e_clo;
      if (x0 > e_chi) x0 = e_chi;
      if (x2 < e_clo) x2 = e_clo;
      if (x2 > e_chi) x2 = e_chi;
    end
    if (e_fmt == 2'd2) begin t = x0; x0 = x2; x2 = t; p = 3'd0; end
    else if (e_fmt == 2'd1) p = 3'd5;
    else p = (e_order > 3'd5) ? 3'd0 : e_order;
    case (p)
      3'd1:    sl = '{x1, x2, x0};
      3'd2:    sl = '{x2, x0, x1};
      3'd3:    sl = '{x0, x2, x1};
      3'd4:    sl = '{x1, x0, x2};
      3'd5:    sl = '{x2, x1, x0};
      default: sl = '{x0, x1, x2};
    endcase
    y = sl[1];
    c = odd ? sl[2] : sl[0];
    case (e_pack)
      3'd1: sl = '{odd ? y : c, 12'd0, 12'd0};
      3'd2: sl = '{odd ? c : y, 12'd0, 12'd0};
      3'd3: sl = '{c, y, 12'd0};
      3'd4: sl = '{y, c, 12'd0};
      default: ;
    endcase
    return {scale(sl[0]), scale(sl[1]), scale(sl[2])};
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected valid", out_word, 48'h0);
      else begin
        logic [47:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(out_word == e, tg, out_word, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; in_line_start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    e_fmt = b_fmt; e_order = b_order; e_pack = b_pack; e_width = b_width;
    e_ylo = b_lim_def ? 12'h010 : b_ylo;
    e_yhi = b_lim_def ? 12'hFE0 : b_yhi;
    e_clo = b_lim_def ? 12'h010 : b_clo;
    e_chi = b_lim_def ? 12'hFE0 : b_chi;
    tb_odd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [11:0] r, input logic [11:0] g, input logic [11:0] b,
                      input bit ls, input string req);
    bit ph;
    @(negedge clk);
    in_valid = 1'b1; in_line_start = ls;
    in_ch0 = r; in_ch1 = g; in_ch2 = b;
    ph = ls ? 1'b0 : tb_odd;
    tb_odd = ~ph;
    exp_q.push_back(model(r, g, b, ph));
    tag_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_line_start = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 missing output", 48'(exp_q.size()), 48'h0);
  endtask

  task automatic t_reset();
    b_fmt = 2'd0; b_order = 3'd0; b_pack = 3'd0; b_width = 3'd2;
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R11 reset valid", 48'(out_valid), 48'h0);
    check(out_word == 48'h0, "R11 reset word", out_word, 48'h0);
    in_valid = 1'b0;
    do_reset();
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && out_word == 48'h0, "R11 idle after reset", out_word, 48'h0);
  endtask

  task automatic t_latency();
    b_fmt = 2'd0; b_order = 3'd0; b_pack = 3'd0; b_width = 3'd2;
    do_reset();
    send(12'hA11, 12'hB22, 12'hC33, 1'b1, "R11 latency data");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R11 not after one clock", 48'(out_valid), 48'h0);
    @(negedge clk);
    check(out_valid == 1'b1, "R11 after two clocks", 48'(out_valid), 48'h1);
    idle();
  endtask

  task automatic t_order();
    for (int k = 0; k < 8; k++) begin
      b_fmt = (k == 7) ? 2'd3 : 2'd0;
      b_order = 3'(k); b_pack = 3'd0; b_width = 3'd2;
      do_reset();
      send(12'h123, 12'h456, 12'h789, 1'b1, "R1 channel order");
      send(12'h000, 12'hFFF, 12'h001, 1'b0, "R1 RGB unclamped");
      idle();
    end
  endtask

  task automatic t_clamp();
    b_fmt = 2'd1; b_order = 3'd1; b_pack = 3'd0; b_width = 3'd2; b_lim_def = 1'b0;
    b_ylo = 12'h100; b_yhi = 12'hE00; b_clo = 12'h080; b_chi = 12'hF00;
    do_reset();
    send(12'h07F, 12'h0FF, 12'hF01, 1'b1, "R2 R3 R5 below/above");
    send(12'h080, 12'h100, 12'hF00, 1'b0, "R2 R3 at limits");
    send(12'h081, 12'hE00, 12'hEFF, 1'b0, "R2 R3 inside");
    send(12'hFFF, 12'hE01, 12'h000, 1'b0, "R2 R3 extremes");
    idle();
    b_lim_def = 1'b1; b_ylo = 12'h400; b_yhi = 12'h500;
    do_reset();
    send(12'h000, 12'h000, 12'hFFF, 1'b1, "R4 default limits");
    send(12'h010, 12'hFE0, 12'h00F, 1'b0, "R4 default edges");
    idle();
    b_lim_def = 1'b0;
  endtask

  task automatic t_422();
    b_fmt = 2'd2; b_order = 3'd5; b_pack = 3'd0; b_width = 3'd2;
    b_ylo = 12'h000; b_yhi = 12'hFFF; b_clo = 12'h000; b_chi = 12'hFFF;
    do_reset();
    send(12'h111, 12'h222, 12'h333, 1'b1, "R6 swap then straight");
    idle();
    for (int m = 3; m <= 4; m++) begin
      b_pack = 3'(m);
      do_reset();
      send(12'h101, 12'h202, 12'h303, 1'b1, "R7 two lane even");
      send(12'h404, 12'h505, 12'h606, 1'b0, "R7 two lane odd");
      send(12'h707, 12'h808, 12'h909, 1'b0, "R7 R9 third pixel");
      send(12'hA0A, 12'hB0B, 12'hC0C, 1'b1, "R9 line start even");
      idle();
    end
  endtask

  task automatic t_onelane();
    for (int m = 1; m <= 2; m++) begin
      b_fmt = 2'd0; b_order = 3'd0; b_pack = 3'(m); b_width = 3'd2;
      do_reset();
      send(12'h11A, 12'h22B, 12'h33C, 1'b1, "R8 one lane even");
      send(12'h44D, 12'h55E, 12'h66F, 1'b0, "R8 one lane odd");
      @(negedge clk);
      in_valid = 1'b0; in_line_start = 1'b1;   // ignored while not valid
      @(negedge clk);
      in_line_start = 1'b0;
      send(12'h777, 12'h888, 12'h999, 1'b0, "R9 held phase even");
      idle();
    end
  endtask

  task automatic t_width();
    for (int w = 0; w < 8; w++) begin
      b_fmt = 2'd0; b_order = 3'd0; b_pack = 3'd0; b_width = 3'(w);
      do_reset();
      send(12'hABC, 12'hFFF, 12'h001, 1'b1, "R10 width code");
      idle();
    end
  endtask

  task automatic t_hold();
    b_fmt = 2'd0; b_order = 3'd0; b_pack = 3'd0; b_width = 3'd2;
    do_reset();
    b_order = 3'd5; b_width = 3'd0; b_fmt = 2'd1;
    send(12'h321, 12'h654, 12'h987, 1'b1, "R12 config held");
    idle();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_order();
    t_clamp();
    t_422();
    t_onelane();
    t_width();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule